// File: doc/BRIEF.md
# Programmable Root Counter Channel

This block is one 16-bit up-counter channel with a compare target and an interrupt line. Each cycle in which its count strobe is high and its pause input is low, the count moves up by one. The channel notes when the count climbs across the compare value and when it rolls over from 0xFFFF to zero. Both events are kept as sticky status bits, which a read of the control word clears. Depending on its configuration, either event can also produce an interrupt.

The interrupt is built around an active-low request bit held in the control word. When an enabled event occurs, the bit is either pulled low for one step (pulse style) or inverted (toggle style). The output `irqOut` is high for exactly one cycle each time that bit falls during a counting step. A one-shot setting lets only the first enabled event act. Later events are ignored until the control word is written again.

Software reaches the channel through a small register port with three registers: the count, the control word and the compare value. The read data is combinational and follows the register select.

Top module: `rccChannel`

## Requirements
- R1: After reset the count, the compare value and the control word all read as zero, and `irqOut` is low.
- R2: The control word (select 1) reads as {3'b0, wrapSeen[12], targetSeen[11], irqN[10], cfg[9:0]}. A read with `regRead` high returns the current value, and bits 12 and 11 read as zero from the next cycle on.
- R3: A write to the control word:
  - replaces cfg[9:0] with the written bits;
  - leaves bits 12:11 unchanged;
  - sets irqN when written bit 10 is 1, and otherwise leaves irqN as it was;
  - clears the count to zero;
  - re-arms the one-shot latch.
- R4: A counting step in which the count was below the compare value before the step, and is at or above it after the step, sets bit 11. If cfg bit 3 is set, the compare value is then subtracted from the new count.
- R5: A counting step from 0xFFFF wraps the count to 0 and sets bit 12.
- R6: An interrupt condition exists when a compare crossing occurs with cfg bit 4 set, or a wrap occurs with cfg bit 5 set.
- R7: When cfg bit 6 is 0 (one-shot), only the first interrupt condition after a control-word write acts. Later conditions are ignored until the next control-word write. When bit 6 is 1, every condition acts.
- R8: A condition that acts inverts irqN when cfg bit 7 is 1 (toggle), and clears irqN when bit 7 is 0 (pulse). In pulse style, irqN reads as 1 after every counting step.
- R9: `irqOut` is high for the one cycle after a counting step in which irqN went from 1 to 0, and low otherwise.
- R10: While `pause` is high, `countStep` has no effect on the count, the status bits, irqN or `irqOut`.
- R11: The count (select 0) and the compare value (select 2) are 16-bit registers that read back what was written. A count write does not change the control word.
- R12: A write to any register in the same cycle as `countStep` takes precedence, and that cycle is not a counting step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| countStep | input | 1 | Count-enable strobe, one step per cycle |
| pause | input | 1 | When high, steps are ignored |
| regSel | input | 2 | Register select: 0 count, 1 control, 2 compare |
| regWrite | input | 1 | Write strobe for the selected register |
| regRead | input | 1 | Read strobe; clears status bits when the control word is selected |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data of the selected register (combinational) |
| irqOut | output | 1 | One-cycle interrupt request |

## Verification
The embedded properties assume that a read of the control word is not issued in the same cycle as a counting step. This is needed because the flag-clearing check expects both bits at zero afterwards, and a step in that cycle could set them again. They also assume that `regSel` never selects the unused code 3 together with a write whose effect is checked.

The stimulus keeps to these assumptions. Every register access occupies a cycle of its own, and steps are applied only with `regWrite` and `regRead` low, except in the one cycle that deliberately tests write precedence. All inputs change on the falling edge, so each step and access is seen at exactly one rising edge.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int DATA_W = 16;
  localparam int CFG_W  = 10;

  // control word bit positions
  localparam int B_RST_TGT  = 3;
  localparam int B_IRQ_TGT  = 4;
  localparam int B_IRQ_WRAP = 5;
  localparam int B_REPEAT   = 6;
  localparam int B_TOGGLE   = 7;
  localparam int B_IRQN     = 10;
  localparam int B_HIT_TGT  = 11;
  localparam int B_HIT_WRAP = 12;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_TARGET = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic stepEn;
    logic cntWr;
    logic modeWr;
    logic tgtWr;
    logic flagClr;
  } ctrl_s;
endpackage

// File: rtl/rcc_datapath.sv
module rcc_datapath
  import rcc_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int CW = CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_s         ctl,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  count,
  output logic [W-1:0]  target,
  output logic [CW-1:0] cfg,
  output logic [1:0]    flags,
  output logic          hitTarget,
  output logic          hitWrap
);
  logic [W-1:0]  countQ, targetQ;
  logic [CW-1:0] cfgQ;
  logic [1:0]    flagsQ;
  logic [W:0]    sum;
  logic [W-1:0]  stepVal;

  assign sum       = {1'b0, countQ} + {{W{1'b0}}, 1'b1};
  assign hitWrap   = ctl.stepEn && sum[W];
  assign hitTarget = ctl.stepEn && (countQ < targetQ) && (sum[W-1:0] >= targetQ);
  assign stepVal   = (hitTarget && cfgQ[B_RST_TGT]) ? (sum[W-1:0] - targetQ) : sum[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      countQ  <= '0;
      targetQ <= '0;
      cfgQ    <= '0;
      flagsQ  <= '0;
    end else begin
      if (ctl.modeWr) begin
        countQ <= '0;
        cfgQ   <= wdata[CW-1:0];
      end else if (ctl.cntWr) begin
        countQ <= wdata;
      end else if (ctl.stepEn) begin
        countQ <= stepVal;
      end
      if (ctl.tgtWr) targetQ <= wdata;
      flagsQ <= (ctl.flagClr ? 2'b00 : flagsQ) | {hitWrap, hitTarget};
    end
  end

  assign count  = countQ;
  assign target = targetQ;
  assign cfg    = cfgQ;
  assign flags  = flagsQ;

  // R2
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.flagClr && !ctl.stepEn |=> flagsQ == 2'b00);
  // R3
  mode_wr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.modeWr |=> countQ == '0);
  // R5
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hitWrap |=> flagsQ[1] && countQ == '0);
endmodule

// File: rtl/rcc_control.sv
module rcc_control
  import rcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] regSel,
  input  logic       regWrite,
  input  logic       regRead,
  input  logic       countStep,
  input  logic       pause,
  input  logic       wIrqBit,
  input  logic       irqTgtEn,
  input  logic       irqWrapEn,
  input  logic       repeatMode,
  input  logic       toggleMode,
  input  logic       hitTarget,
  input  logic       hitWrap,
  output ctrl_s      ctl,
  output logic       irqN,
  output logic       irqOut
);
  logic irqNQ, latchQ, irqQ;
  logic cond, act, irqNAfter;

  always_comb begin
    ctl.cntWr   = regWrite && (regSel == SEL_COUNT);
    ctl.modeWr  = regWrite && (regSel == SEL_MODE);
    ctl.tgtWr   = regWrite && (regSel == SEL_TARGET);
    ctl.flagClr = regRead && (regSel == SEL_MODE);
    ctl.stepEn  = countStep && !pause && !regWrite;
  end

  assign cond      = (hitTarget && irqTgtEn) || (hitWrap && irqWrapEn);
  assign act       = cond && !(!repeatMode && latchQ);
  assign irqNAfter = act ? (toggleMode ? ~irqNQ : 1'b0) : irqNQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqNQ  <= 1'b0;
      latchQ <= 1'b0;
      irqQ   <= 1'b0;
    end else if (ctl.modeWr) begin
      irqNQ  <= irqNQ | wIrqBit;
      latchQ <= 1'b0;
      irqQ   <= 1'b0;
    end else if (ctl.stepEn) begin
      irqQ  <= irqNQ && !irqNAfter;
      irqNQ <= toggleMode ? irqNAfter : 1'b1;
      if (act && !repeatMode) latchQ <= 1'b1;
    end else begin
      irqQ <= 1'b0;
    end
  end

  assign irqN   = irqNQ;
  assign irqOut = irqQ;

  // R9
  irq_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqQ |-> $past(ctl.stepEn) && !irqNQ || $past(ctl.stepEn) && !toggleMode);
  // R8
  pulse_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.stepEn && !toggleMode |=> irqNQ);
  // R7
  one_shot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latchQ && !repeatMode |=> !irqQ);
  // R3
  latch_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.modeWr |=> !latchQ && !irqQ);
endmodule

// File: rtl/rccChannel.sv
module rccChannel
  import rcc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        countStep,
  input  logic        pause,
  input  logic [1:0]  regSel,
  input  logic        regWrite,
  input  logic        regRead,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  output logic        irqOut
);
  ctrl_s             ctl;
  logic [DATA_W-1:0] count, target, modeView;
  logic [CFG_W-1:0]  cfg;
  logic [1:0]        flags;
  logic              hitTarget, hitWrap, irqN;

  rcc_datapath #(.W(DATA_W), .CW(CFG_W)) uDatapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wdata(regWdata),
    .count(count), .target(target), .cfg(cfg), .flags(flags),
    .hitTarget(hitTarget), .hitWrap(hitWrap)
  );

  rcc_control uControl (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .regWrite(regWrite),
    .regRead(regRead), .countStep(countStep), .pause(pause),
    .wIrqBit(regWdata[B_IRQN]),
    .irqTgtEn(cfg[B_IRQ_TGT]), .irqWrapEn(cfg[B_IRQ_WRAP]),
    .repeatMode(cfg[B_REPEAT]), .toggleMode(cfg[B_TOGGLE]),
    .hitTarget(hitTarget), .hitWrap(hitWrap),
    .ctl(ctl), .irqN(irqN), .irqOut(irqOut)
  );

  always_comb begin
    modeView             = '0;
    modeView[CFG_W-1:0]  = cfg;
    modeView[B_IRQN]     = irqN;
    modeView[B_HIT_TGT]  = flags[0];
    modeView[B_HIT_WRAP] = flags[1];
  end

  always_comb begin
    unique case (regSel)
      SEL_COUNT:  regRdata = count;
      SEL_MODE:   regRdata = modeView;
      SEL_TARGET: regRdata = target;
      default:    regRdata = '0;
    endcase
  end

  // R10
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause && !regWrite |=> $stable(count) && !irqOut);
  // R12
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regWrite && regSel == SEL_COUNT |=> count == $past(regWdata));
endmodule

// File: tb/rccChannel_test.sv
module rccChannel_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        countStep = 1'b0, pause = 1'b0, regWrite = 1'b0, regRead = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irqOut;

  int nChecks = 0, nFail = 0;

  // reference state
  logic [15:0] mCnt, mTgt;
  logic [9:0]  mCfg;
  logic        mIrqN, mLatch, mHitT, mHitW, expIrq;

  rccChannel uut (
    .clk(clk), .rst_n(rst_n), .countStep(countStep), .pause(pause),
    .regSel(regSel), .regWrite(regWrite), .regRead(regRead),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] modelMode();
    return {3'b000, mHitW, mHitT, mIrqN, mCfg};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(logic [1:0] sel, string req, logic [15:0] exp);
    regSel = sel;
    #1;
    check(req, regRdata, exp);
  endtask

  task automatic writeReg(logic [1:0] sel, logic [15:0] d);
    regSel = sel; regWdata = d; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
    case (sel)
      2'd0: mCnt = d;
      2'd1: begin mCfg = d[9:0]; if (d[10]) mIrqN = 1'b1; mCnt = '0; mLatch = 1'b0; end
      2'd2: mTgt = d;
      default: ;
    endcase
  endtask

  task automatic modelStep();
    logic [16:0] s;
    logic reached, wrap, cond, act, old;
    expIrq = 1'b0;
    if (pause) return;
    old = mIrqN;
    s = {1'b0, mCnt} + 17'd1;
    wrap = s[16];
    reached = (mCnt < mTgt) && (s[15:0] >= mTgt);
    mCnt = s[15:0];
    if (reached) begin mHitT = 1'b1; if (mCfg[3]) mCnt = mCnt - mTgt; end
    if (wrap) mHitW = 1'b1;
    cond = (reached && mCfg[4]) || (wrap && mCfg[5]);
    act = cond && !(!mCfg[6] && mLatch);
    if (act) begin
      if (!mCfg[6]) mLatch = 1'b1;
      mIrqN = mCfg[7] ? ~mIrqN : 1'b0;
    end
    expIrq = old && !mIrqN;
    if (!mCfg[7]) mIrqN = 1'b1;
  endtask

  // one step; checks R9 on irqOut and R4/R5/R8 through the count and control word
  task automatic doStep();
    countStep = 1'b1;
    @(negedge clk);
    countStep = 1'b0;
    modelStep();
    #1;
    check("R9 irqOut", {15'b0, irqOut}, {15'b0, expIrq});
    peek(2'd0, "R4/R5 count", mCnt);
    peek(2'd1, "R8 control word", modelMode());
  endtask

  task automatic readMode();
    regSel = 2'd1; regRead = 1'b1;
    #1;
    check("R2 read value", regRdata, modelMode());
    @(negedge clk);
    regRead = 1'b0;
    mHitT = 1'b0; mHitW = 1'b0;
    peek(2'd1, "R2 flags cleared", modelMode());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    mCnt = '0; mTgt = '0; mCfg = '0; mIrqN = 1'b0; mLatch = 1'b0;
    mHitT = 1'b0; mHitW = 1'b0; expIrq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(2'd0, "R1 count", 16'h0);
    peek(2'd1, "R1 control", 16'h0);
    peek(2'd2, "R1 compare", 16'h0);
    check("R1 irqOut", {15'b0, irqOut}, 16'h0);

    // sweep over all event/interrupt configurations, compare values and start points
    for (int m = 0; m < 32; m++) begin
      for (int t = 0; t < 4; t++) begin
        for (int s = 0; s < 2; s++) begin
          logic [15:0] tgt, start, md;
          tgt   = (t == 0) ? 16'h0 : (t == 1) ? 16'h1 : (t == 2) ? 16'h3 : 16'hFFFF;
          start = s ? 16'hFFFD : 16'h0;
          md    = {5'b0, 1'(m ^ t), 2'(m + t), 5'(m), (s ? 3'd5 : 3'd2)};
          writeReg(2'd2, tgt);
          peek(2'd2, "R11 compare readback", mTgt);
          writeReg(2'd0, 16'h5A5A);
          writeReg(2'd1, md);
          peek(2'd0, "R3 count cleared", 16'h0);
          peek(2'd1, "R3 control written", modelMode());
          writeReg(2'd0, start);
          peek(2'd0, "R11 count readback", mCnt);
          peek(2'd1, "R11 control untouched", modelMode());
          for (int k = 0; k < 10; k++) doStep();
          readMode();
        end
      end
    end

    // R10: pause blocks steps (repeat, pulse, irq on compare, compare 2)
    writeReg(2'd2, 16'h2);
    writeReg(2'd1, 16'h0458);
    pause = 1'b1;
    for (int k = 0; k < 5; k++) begin
      countStep = 1'b1;
      @(negedge clk);
      countStep = 1'b0;
      #1;
      check("R10 irqOut paused", {15'b0, irqOut}, 16'h0);
      peek(2'd0, "R10 count paused", mCnt);
      peek(2'd1, "R10 control paused", modelMode());
    end
    pause = 1'b0;
    doStep();
    doStep();
    check("R6 compare interrupt", {15'b0, irqOut}, 16'h1);

    // R12: write coincident with a step wins
    countStep = 1'b1;
    writeReg(2'd0, 16'h1234);
    countStep = 1'b0;
    peek(2'd0, "R12 write wins", 16'h1234);
    check("R12 no irq", {15'b0, irqOut}, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule